// File: doc/BRIEF.md
# Scaled Integer Block Dot-Product Pipeline

This unit takes two blocks of 32 signed 8-bit integers, each block paired with an 8-bit power-of-two scale byte, and returns their exact dot product. Each pair of elements is multiplied, and the 32 products are reduced by a balanced binary adder tree. Every level of the tree is one bit wider than the level below it, so no sum is ever rounded or saturated. The scales are never applied to individual elements. The two scale bytes are unbiased (bias 127) and added once per block, which gives a single combined exponent. The real value of the result is `sum_o * 2^exp_o`.

The datapath is fully pipelined. One register follows the multiplier array and one follows each of the five tree levels, so every result arrives six clock edges after its inputs were sampled. A new pair of blocks can be presented on every cycle. A scale byte of all ones marks its block as not-a-number. That flag travels down the pipeline with the block, and it clears the integer sum and the exponent of the result.

Top module: `mx_dot_unit`

## Requirements
- R1: `sum_o` equals the exact sum over i of a_i*b_i, where element i of each vector sits at bits [8i+7:8i] and is read as 8-bit two's complement.
- R2: `sum_o` is 21-bit two's complement and holds the extremes without wrap: all elements -128 times -128 gives 524288, and all -128 times 127 gives -520192.
- R3: When neither scale byte is 0xFF, `exp_o` equals (a_scale-127)+(b_scale-127) as 10-bit two's complement. This value ranges from -254 to +254.
- R4: If either scale byte equals 0xFF, then `nan_o` is 1 and both `sum_o` and `exp_o` are 0 for that block. Otherwise `nan_o` is 0.
- R5: `valid_o` is high in exactly the cycles that follow the sixth rising edge after a rising edge at which `valid_i` was high. The result fields in those cycles belong to that block. A sampled low `valid_i` gives a low `valid_o` six edges later.
- R6: Blocks presented on consecutive cycles come out on consecutive cycles, in order, and each result is independent of its neighbours.
- R7: While `rst_ni` is low, `valid_o`, `nan_o`, `sum_o` and `exp_o` are 0 at once, without waiting for a clock edge. Blocks that are in flight when reset is asserted never appear at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input block pair is present |
| a_elems_i | input | 256 | 32 packed signed 8-bit elements of block A |
| b_elems_i | input | 256 | 32 packed signed 8-bit elements of block B |
| a_scale_i | input | 8 | Biased exponent of block A, 0xFF = NaN |
| b_scale_i | input | 8 | Biased exponent of block B, 0xFF = NaN |
| valid_o | output | 1 | Result is present |
| sum_o | output | 21 | Exact integer dot product |
| exp_o | output | 10 | Combined unbiased exponent |
| nan_o | output | 1 | Result is not a number |

## Verification
The assertions assume that the element and scale inputs are known values whenever `valid_i` is high. They also assume that `valid_i` is held low for the whole of reset. The bench changes every input only on the falling clock edge. It keeps `valid_i` low whenever it asserts or releases reset. It draws the element and scale values from a full random range, and it adds directed extremes and 0xFF scale bytes, so the magnitude and exponent bounds are reached by legal traffic only.

// File: rtl/mx_dot_pkg.sv
package mx_dot_pkg;
  function automatic int prod_width(input int elem_w);
    return 2 * elem_w;
  endfunction

  function automatic int tree_levels(input int n_elem);
    return $clog2(n_elem);
  endfunction

  function automatic int sum_width(input int elem_w, input int n_elem);
    return 2 * elem_w + $clog2(n_elem);
  endfunction

  function automatic int exp_width(input int scale_w);
    return scale_w + 2;
  endfunction
endpackage

// File: rtl/mx_mul_stage.sv
module mx_mul_stage #(
  parameter int N_ELEM = 32,
  parameter int ELEM_W = 8,
  localparam int PW = mx_dot_pkg::prod_width(ELEM_W)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_ELEM*ELEM_W-1:0] a_i,
  input  logic [N_ELEM*ELEM_W-1:0] b_i,
  output logic [N_ELEM*PW-1:0]   prod_o
);
  logic [N_ELEM*PW-1:0] prod_d;

  always_comb begin
    for (int i = 0; i < N_ELEM; i++) begin
      logic signed [ELEM_W-1:0] ea, eb;
      ea = a_i[i*ELEM_W +: ELEM_W];
      eb = b_i[i*ELEM_W +: ELEM_W];
      prod_d[i*PW +: PW] = PW'(ea) * PW'(eb);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prod_o <= '0;
    else         prod_o <= prod_d;
endmodule

// File: rtl/mx_tree_level.sv
module mx_tree_level #(
  parameter int IN_CNT = 32,
  parameter int IN_W   = 16,
  localparam int OUT_CNT = IN_CNT / 2,
  localparam int OUT_W   = IN_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [IN_CNT*IN_W-1:0]   din_i,
  output logic [OUT_CNT*OUT_W-1:0] dout_o
);
  logic [OUT_CNT*OUT_W-1:0] dout_d;

  // sign-extend each operand by one bit, so the add is exact
  always_comb begin
    for (int i = 0; i < OUT_CNT; i++) begin
      dout_d[i*OUT_W +: OUT_W] =
        {din_i[(2*i+1)*IN_W-1], din_i[2*i*IN_W +: IN_W]} +
        {din_i[(2*i+2)*IN_W-1], din_i[(2*i+1)*IN_W +: IN_W]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) dout_o <= '0;
    else         dout_o <= dout_d;
endmodule

// File: rtl/mx_scale_path.sv
module mx_scale_path #(
  parameter int SCALE_W = 8,
  parameter int BIAS    = 127,
  parameter int DEPTH   = 6,
  localparam int EW     = mx_dot_pkg::exp_width(SCALE_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [SCALE_W-1:0] sa_i,
  input  logic [SCALE_W-1:0] sb_i,
  output logic               valid_o,
  output logic               nan_o,
  output logic [EW-1:0]      exp_o
);
  logic          nan_d;
  logic [EW-1:0] exp_d;
  logic [DEPTH-1:0] v_q, n_q;
  logic [EW-1:0] e_q [DEPTH];

  assign nan_d = (&sa_i) | (&sb_i);
  assign exp_d = nan_d ? '0 :
                 EW'({2'b00, sa_i}) + EW'({2'b00, sb_i}) - EW'(2 * BIAS);

  for (genvar s = 0; s < DEPTH; s++) begin : g_stg
    if (s == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          v_q[0] <= 1'b0; n_q[0] <= 1'b0; e_q[0] <= '0;
        end else begin
          v_q[0] <= valid_i; n_q[0] <= nan_d; e_q[0] <= exp_d;
        end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          v_q[s] <= 1'b0; n_q[s] <= 1'b0; e_q[s] <= '0;
        end else begin
          v_q[s] <= v_q[s-1]; n_q[s] <= n_q[s-1]; e_q[s] <= e_q[s-1];
        end
    end
  end

  assign valid_o = v_q[DEPTH-1];
  assign nan_o   = n_q[DEPTH-1];
  assign exp_o   = e_q[DEPTH-1];
endmodule

// File: rtl/mx_dot_unit.sv
module mx_dot_unit #(
  parameter int N_ELEM  = 32,
  parameter int ELEM_W  = 8,
  parameter int SCALE_W = 8,
  parameter int BIAS    = 127,
  localparam int LEVELS = mx_dot_pkg::tree_levels(N_ELEM),
  localparam int PW     = mx_dot_pkg::prod_width(ELEM_W),
  localparam int SW     = mx_dot_pkg::sum_width(ELEM_W, N_ELEM),
  localparam int EW     = mx_dot_pkg::exp_width(SCALE_W),
  localparam int LAT    = LEVELS + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [N_ELEM*ELEM_W-1:0] a_elems_i,
  input  logic [N_ELEM*ELEM_W-1:0] b_elems_i,
  input  logic [SCALE_W-1:0]       a_scale_i,
  input  logic [SCALE_W-1:0]       b_scale_i,
  output logic                     valid_o,
  output logic [SW-1:0]            sum_o,
  output logic [EW-1:0]            exp_o,
  output logic                     nan_o
);
  logic [N_ELEM*PW-1:0] prod_q;
  logic [SW-1:0]        tree_q;

  mx_mul_stage #(.N_ELEM(N_ELEM), .ELEM_W(ELEM_W)) u_mul (
    .clk_i, .rst_ni, .a_i(a_elems_i), .b_i(b_elems_i), .prod_o(prod_q)
  );

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int CNT = N_ELEM >> l;
    localparam int IW  = PW + l;
    logic [CNT*IW-1:0]           din;
    logic [(CNT/2)*(IW+1)-1:0]   dout;
    if (l == 0) begin : g_first
      assign din = prod_q;
    end else begin : g_next
      assign din = g_lvl[l-1].dout;
    end
    mx_tree_level #(.IN_CNT(CNT), .IN_W(IW)) u_lvl (
      .clk_i, .rst_ni, .din_i(din), .dout_o(dout)
    );
  end

  assign tree_q = g_lvl[LEVELS-1].dout;

  mx_scale_path #(.SCALE_W(SCALE_W), .BIAS(BIAS), .DEPTH(LAT)) u_scl (
    .clk_i, .rst_ni, .valid_i,
    .sa_i(a_scale_i), .sb_i(b_scale_i),
    .valid_o, .nan_o, .exp_o
  );

  assign sum_o = nan_o ? '0 : tree_q;
endmodule

// File: rtl/mx_dot_chk.sv
module mx_dot_chk #(
  parameter int N_ELEM  = 32,
  parameter int ELEM_W  = 8,
  parameter int SCALE_W = 8,
  parameter int SW      = 21,
  parameter int EW      = 10,
  parameter int LAT     = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [SCALE_W-1:0] a_scale_i,
  input logic [SCALE_W-1:0] b_scale_i,
  input logic               valid_o,
  input logic [SW-1:0]      sum_o,
  input logic [EW-1:0]      exp_o,
  input logic               nan_o
);
  localparam longint MAG = longint'(N_ELEM) << (2 * ELEM_W - 2);
  localparam int     EMAX = 2 * ((1 << SCALE_W) - 2 - ((1 << (SCALE_W - 1)) - 1));

  logic [LAT-1:0] v_sh, n_sh;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      v_sh <= '0; n_sh <= '0;
    end else begin
      v_sh <= {v_sh[LAT-2:0], valid_i};
      n_sh <= {n_sh[LAT-2:0], valid_i & ((&a_scale_i) | (&b_scale_i))};
    end

  // R5
  a_r5_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == v_sh[LAT-1]);
  // R4
  a_r4_nan_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (nan_o == n_sh[LAT-1]));
  a_r4_nan_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nan_o |-> (sum_o == '0 && exp_o == '0));
  // R2
  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($signed(sum_o) <= MAG && $signed(sum_o) >= -MAG));
  // R3
  a_r3_exp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !nan_o) |-> ($signed(exp_o) <= EMAX && $signed(exp_o) >= -EMAX));
  // R7
  a_r7_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !nan_o && sum_o == '0 && exp_o == '0));
endmodule

bind mx_dot_unit mx_dot_chk #(
  .N_ELEM(N_ELEM), .ELEM_W(ELEM_W), .SCALE_W(SCALE_W),
  .SW(SW), .EW(EW), .LAT(LAT)
) u_chk (.*);

// File: tb/sim_mx_dot_unit.sv
module sim_mx_dot_unit;
  localparam int N = 32;
  localparam int LAT = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [N*8-1:0] a_elems_i = '0, b_elems_i = '0;
  logic [7:0] a_scale_i = 8'd127, b_scale_i = 8'd127;
  logic valid_o, nan_o;
  logic [20:0] sum_o;
  logic [9:0] exp_o;

  int total = 0, bad = 0;
  string tag = "R1";

  always #10 clk_i = ~clk_i;

  mx_dot_unit u0 (.*);

  typedef struct {bit v; int sum; int ex; bit nan;} exp_t;
  exp_t q[$];

  function automatic exp_t model(bit v, logic [N*8-1:0] a, logic [N*8-1:0] b,
                                 logic [7:0] sa, logic [7:0] sb);
    exp_t e;
    e.v = v; e.sum = 0;
    for (int i = 0; i < N; i++)
      e.sum += int'($signed(a[i*8 +: 8])) * int'($signed(b[i*8 +: 8]));
    e.nan = (sa == 8'hFF) || (sb == 8'hFF);
    e.ex  = int'(sa) + int'(sb) - 254;
    if (e.nan) begin e.sum = 0; e.ex = 0; end
    return e;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // per-clock reference comparison
  always @(posedge clk_i) begin
    if (!rst_ni) q.delete();
    else begin
      q.push_back(model(valid_i, a_elems_i, b_elems_i, a_scale_i, b_scale_i));
      if (q.size() > LAT) void'(q.pop_front());
    end
    #5;
    if (q.size() < LAT) chk(valid_o == 1'b0, {"R5/R7 ", tag}, int'(valid_o), 0);
    else begin
      chk(valid_o == q[0].v, {"R5 ", tag}, int'(valid_o), int'(q[0].v));
      if (q[0].v) begin
        chk($signed(sum_o) == q[0].sum, {"R1 ", tag}, $signed(sum_o), q[0].sum);
        chk($signed(exp_o) == q[0].ex, {"R3 ", tag}, $signed(exp_o), q[0].ex);
        chk(nan_o == q[0].nan, {"R4 ", tag}, int'(nan_o), int'(q[0].nan));
      end
    end
  end

  task automatic drive(bit v, logic [N*8-1:0] a, logic [N*8-1:0] b,
                       logic [7:0] sa, logic [7:0] sb);
    @(negedge clk_i);
    valid_i = v; a_elems_i = a; b_elems_i = b; a_scale_i = sa; b_scale_i = sb;
  endtask

  function automatic logic [N*8-1:0] fill(logic [7:0] x);
    logic [N*8-1:0] r;
    for (int i = 0; i < N; i++) r[i*8 +: 8] = x;
    return r;
  endfunction

  function automatic logic [N*8-1:0] rnd_vec();
    logic [N*8-1:0] r;
    for (int i = 0; i < N; i++) r[i*8 +: 8] = 8'($urandom);
    return r;
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, '0, '0, 8'd127, 8'd127);
  endtask

  initial begin
    #4_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N*8-1:0] ramp;
    // R7 reset state
    #1;
    tag = "R7";
    chk(valid_o == 0 && nan_o == 0, "R7 reset flags", int'(valid_o), 0);
    chk(sum_o == 0 && exp_o == 0, "R7 reset data", int'(sum_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 ramp pattern, element i = i-16 times 3
    tag = "R1 ramp";
    for (int i = 0; i < N; i++) ramp[i*8 +: 8] = 8'(i - 16);
    drive(1, ramp, fill(8'd3), 8'd127, 8'd127);
    drive(1, fill(8'h00), rnd_vec(), 8'd130, 8'd100);
    idle(1);

    // R2 extremes, checked directly at the ports too
    tag = "R2";
    drive(1, fill(8'h80), fill(8'h80), 8'd127, 8'd127);
    drive(1, fill(8'h80), fill(8'h7F), 8'd127, 8'd127);
    idle(1);
    repeat (3) @(negedge clk_i);
    @(posedge clk_i); #5;
    chk($signed(sum_o) == 524288 && valid_o, "R2 max positive", $signed(sum_o), 524288);
    @(posedge clk_i); #5;
    chk($signed(sum_o) == -520192 && valid_o, "R2 max negative", $signed(sum_o), -520192);

    // R3 exponent boundaries
    tag = "R3";
    drive(1, rnd_vec(), rnd_vec(), 8'd0, 8'd0);
    drive(1, rnd_vec(), rnd_vec(), 8'd254, 8'd254);
    drive(1, rnd_vec(), rnd_vec(), 8'd0, 8'd254);
    drive(1, rnd_vec(), rnd_vec(), 8'd127, 8'd1);
    idle(2);

    // R4 NaN on either side and both
    tag = "R4";
    drive(1, fill(8'h7F), fill(8'h7F), 8'hFF, 8'd127);
    drive(1, fill(8'h7F), fill(8'h7F), 8'd10, 8'hFF);
    drive(1, rnd_vec(), rnd_vec(), 8'hFF, 8'hFF);
    drive(1, rnd_vec(), rnd_vec(), 8'hFE, 8'hFE);
    idle(2);

    // R6 back-to-back stream with random gaps; R5 via model
    tag = "R6";
    for (int k = 0; k < 400; k++) begin
      logic [7:0] sa, sb;
      sa = ($urandom % 16 == 0) ? 8'hFF : 8'($urandom);
      sb = ($urandom % 16 == 0) ? 8'hFF : 8'($urandom);
      drive(k < 100 ? 1'b1 : 1'($urandom % 3 != 0), rnd_vec(), rnd_vec(), sa, sb);
    end

    // R7 reset with blocks in flight
    tag = "R7 flush";
    for (int k = 0; k < 4; k++) drive(1, rnd_vec(), rnd_vec(), 8'd120, 8'd140);
    @(negedge clk_i);
    valid_i = 0; rst_ni = 0;
    #1;
    chk(valid_o == 0 && sum_o == 0, "R7 async clear", int'(valid_o), 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    idle(LAT + 2);
    drive(1, ramp, ramp, 8'd127, 8'd127);
    idle(LAT + 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule